// File: doc/BRIEF.md
# Eight-Pin Bidirectional I/O Port

This block is one general-purpose I/O port of eight pins. Software sees three registers on a small register-mapped bus: a level register that holds the value each output pin drives, a direction register that decides per pin whether the pin drives or listens, and a read-only sample register that holds the synchronized pin levels. For every pin the block sends three signals to a pad model outside it: the level to drive, an output enable, and a pull-up enable.

A pin set as a listener uses its level bit for a second purpose. A 1 in that bit turns on the pin's weak pull-up. A sideband debug enable keeps the pull-ups on a fixed group of pins switched on in every state. Those pins are the debug data-in, mode-select and clock lines, which are bits 7, 5 and 4 by default. The override holds while reset is active. Reset is asynchronous. It puts every pin in high impedance at once, without needing a clock edge.

Top module: `gpio_port8`

## Requirements
- R1: For each pin, output enable `pad_oe[i]` equals direction bit i. Bit value 1 means drive and 0 means listen.
- R2: `pad_out[i]` equals level-register bit i, so a driving pin with level 1 drives high and with level 0 drives low.
- R3: Outside the debug group, `pad_pu[i]` is 1 exactly when direction bit i is 0 and level bit i is 1. A driving pin never has its pull-up on.
- R4: While `rst_n` is low, `pad_oe` is all zeros, including when the clock is stopped.
- R5: While `dbg_en` is 1, `pad_pu` is 1 on every pin of the debug mask (default 8'hB0, bits 7, 5, 4), whatever the direction, level or reset state.
- R6: Reset clears the level and direction registers to 8'h00.
- R7: Register offsets are: 0 for the level register, 1 for direction, 2 for the pin sample, and 3 for no register (reads 8'h00). `bus_rdata` shows the register selected by `bus_addr` in the cycle after that address is presented, with the value held before any write at that same edge.
- R8: A write to offset 2 changes neither the level nor the direction register.
- R9: The pin sample register takes `pin_in` through two flip-flops, whatever the direction. A pin change set up before edge k is read back at offset 2 after edge k+2, and not before.
- R10: A write (`bus_wr`=1) to offset 0 or 1 updates that register at the clock edge. The new value is visible on the pads right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| dbg_en | input | 1 | Debug enable, forces pull-ups on debug pins |
| pin_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Level to drive per pin |
| pad_oe | output | 8 | Output enable per pin |
| pad_pu | output | 8 | Pull-up enable per pin |

## Verification
The bench checks the two-edge sampling latency with pins set as drivers. A design with one stage too few or too many would show the new pin value one cycle early or one cycle late. It asserts reset while the clock is stopped and `dbg_en` is high. This catches a tri-state that waits for a clock edge, and a debug override that reset clears. Writes to the sample offset and reads of the empty offset expose a decoder that aliases offsets. Mixed direction and level patterns show pull-ups that leak onto driving pins or that ignore the level bit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LEVEL = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_PINS  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_sync_o = st_q.s2;

    // R9: second stage follows first stage by exactly one edge
    a_r9_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s2 == $past(st_q.s1));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      pins_i,
    output logic [W-1:0]      level_o,
    output logic [W-1:0]      dir_o,
    output logic [W-1:0]      rdata_o
);
    typedef struct packed {
        logic [W-1:0] level;
        logic [W-1:0] dir;
        logic [W-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    reg_sel_e sel;

    always_comb begin
        sel  = reg_sel_e'(addr_i);
        st_d = st_q;
        unique case (sel)
            SEL_LEVEL: st_d.rdata = st_q.level;
            SEL_DIR:   st_d.rdata = st_q.dir;
            SEL_PINS:  st_d.rdata = pins_i;
            default:   st_d.rdata = '0;
        endcase
        if (wr_i) begin
            if (sel == SEL_LEVEL) st_d.level = wdata_i;
            if (sel == SEL_DIR)   st_d.dir   = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;
    assign dir_o   = st_q.dir;
    assign rdata_o = st_q.rdata;

    // R8: writes aimed at the sample offset leave both control registers alone
    a_r8_pin_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 2'd2) |=> ($stable(level_o) && $stable(dir_o)));

    // R7: direction readback arrives one cycle after the address
    a_r7_dir_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 2'd1) |=> (rdata_o == $past(dir_o)));

    // R7: the empty offset reads zero
    a_r7_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 2'd3) |=> (rdata_o == '0));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
    parameter int unsigned W        = 8,
    parameter logic [W-1:0] DBG_MASK = 8'hB0
) (
    input  logic         rst_n,
    input  logic         dbg_en,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] dir_i,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic listen;
        assign listen     = ~dir_i[i];
        assign pad_out[i] = level_i[i];
        assign pad_oe[i]  = dir_i[i] & rst_n;
        if (DBG_MASK[i]) begin : g_dbg
            assign pad_pu[i] = dbg_en | (listen & level_i[i] & rst_n);
        end else begin : g_plain
            assign pad_pu[i] = listen & level_i[i] & rst_n;
        end
    end

    always_comb begin
        // R4: no pin drives while reset is held
        if (!rst_n) a_r4_tristate_in_reset: assert (pad_oe == '0);
        // R5: debug pins keep their pull-ups whenever debug is enabled
        if (dbg_en) a_r5_debug_pullups: assert ((pad_pu & DBG_MASK) == DBG_MASK);
        // R3: a driving pin outside the debug group has no pull-up
        a_r3_no_pull_on_driver: assert ((pad_pu & pad_oe & ~DBG_MASK) == '0);
    end
endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
    import gpio_port_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter logic [W-1:0] DBG_MASK = 8'hB0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              dbg_en,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_pu
);
    logic [W-1:0] pins_sync;
    logic [W-1:0] level_q;
    logic [W-1:0] dir_q;

    gpio_sync #(.W(W)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_in),
        .pin_sync_o (pins_sync)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .pins_i  (pins_sync),
        .level_o (level_q),
        .dir_o   (dir_q),
        .rdata_o (bus_rdata)
    );

    gpio_pad_ctl #(.W(W), .DBG_MASK(DBG_MASK)) u_pad (
        .rst_n   (rst_n),
        .dbg_en  (dbg_en),
        .level_i (level_q),
        .dir_i   (dir_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );
endmodule

// File: tb/gpio_port8_bench.sv
module gpio_port8_bench;
    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       dbg_en = 1'b0;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pad_out, pad_oe, pad_pu;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    localparam logic [7:0] DBG = 8'hB0;

    // behavioural reference state
    logic [7:0] m_level, m_dir, m_rd;
    logic [7:0] m_pipe [$];

    gpio_port8 u_gpio_port8 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_en(dbg_en),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    always #2 clk = clk_run ? ~clk : clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_pu();
        return (rst_n ? (~m_dir & m_level) : 8'h00) | (dbg_en ? DBG : 8'h00);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_level = 8'h00; m_dir = 8'h00; m_rd = 8'h00;
            m_pipe = {8'h00, 8'h00};
        end else begin
            case (bus_addr)
                2'd0: m_rd = m_level;
                2'd1: m_rd = m_dir;
                2'd2: m_rd = m_pipe[0];
                default: m_rd = 8'h00;
            endcase
            if (bus_wr && bus_addr == 2'd0) m_level = bus_wdata;
            if (bus_wr && bus_addr == 2'd1) m_dir   = bus_wdata;
            void'(m_pipe.pop_front());
            m_pipe.push_back(pin_in);
        end
    end

    // compare every clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk("R7 rdata", bus_rdata, m_rd);
            chk("R1 oe", pad_oe, rst_n ? m_dir : 8'h00);
            chk("R2 out", pad_out, m_level);
            chk("R3 pu", pad_pu, exp_pu());
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog all requirements actual=%0d expected=<50000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk); #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        #1;
        chk("R4 oe in reset", pad_oe, 8'h00);
        chk("R3 pu in reset", pad_pu, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_chk(2'd0, 8'h00, "R6 level after reset");
        rd_chk(2'd1, 8'h00, "R6 dir after reset");

        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h0F);
        #1;
        chk("R1 oe follows dir", pad_oe, 8'h0F);
        chk("R2 out follows level", pad_out, 8'hA5);
        chk("R3 pull on listening ones", pad_pu, 8'hA0);
        rd_chk(2'd0, 8'hA5, "R10 level readback");
        rd_chk(2'd1, 8'h0F, "R10 dir readback");

        wr(2'd2, 8'hFF);
        rd_chk(2'd0, 8'hA5, "R8 level unchanged");
        rd_chk(2'd1, 8'h0F, "R8 dir unchanged");
        rd_chk(2'd3, 8'h00, "R7 empty offset");

        // sampling latency with all pins driving
        wr(2'd1, 8'hFF);
        @(negedge clk);
        bus_addr = 2'd2;
        @(negedge clk);
        pin_in = 8'h3C;
        @(posedge clk); #1; chk("R9 not after edge k", bus_rdata, 8'h00);
        @(posedge clk); #1; chk("R9 not after edge k+1", bus_rdata, 8'h00);
        @(posedge clk); #1; chk("R9 seen after edge k+2", bus_rdata, 8'h3C);
        @(negedge clk); pin_in = 8'hC3;
        repeat (3) @(posedge clk); #1;
        chk("R9 second pattern", bus_rdata, 8'hC3);

        // pull-up pattern mix
        wr(2'd1, 8'h55);
        wr(2'd0, 8'hFF);
        #1;
        chk("R3 pull only on listeners", pad_pu, 8'hAA);
        wr(2'd0, 8'h0F);
        #1;
        chk("R3 level zero no pull", pad_pu, 8'h0A);

        // debug override
        wr(2'd1, 8'hFF);
        @(negedge clk); dbg_en = 1'b1; #1;
        chk("R5 debug pulls on drivers", pad_pu, DBG);
        repeat (4) @(posedge clk);

        // reset with clock stopped
        @(negedge clk);
        clk_run = 1'b0;
        #3;
        rst_n = 1'b0;
        #1;
        chk("R4 oe with no clock", pad_oe, 8'h00);
        chk("R5 debug pulls in reset", pad_pu, DBG);
        chk("R6 level cleared", pad_out, 8'h00);
        dbg_en = 1'b0; #1;
        chk("R3 no pull in reset", pad_pu, 8'h00);
        #5;
        clk_run = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_chk(2'd1, 8'h00, "R6 dir cleared");
        repeat (5) @(posedge clk);
        #2;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule